// File: doc/BRIEF.md
# MDIO Management Access Controller

This block is a management-bus master that performs one PHY register read or write at a time on a two-wire serial management interface. Software fills a single 32-bit command word with the target PHY address, the register address, the direction and, for a write, the data. Setting the start flag in that word launches the access. The block generates the management clock from the system clock and shifts a complete frame out on the data line. For a read, it releases the line and samples the turnaround acknowledge and the 16 returned bits. The result lands in the same command word, and the start flag drops when the access is done.

A simple register bus gives access to the command word. A write strobe with write data updates it, and the read data port always shows the current contents. An enable input gates whether new accesses may be started. The start flag acts as a lock: while it is set, the command word ignores every bus write. Software can therefore poll the word, without races, until the start flag reads 0.

Top module: `mdio_acc_ctrl`

## Requirements
- R1: After reset the command word reads 0x0000_0000, `idle_o` is 1, `mdio_oe_o` is 0 and `mdc_o` is 0.
- R2: Command word layout: bit 31 start flag, bit 30 direction (1 = write, 0 = read), bit 29 acknowledge flag, bits 28..26 always read 0, bits 25..21 register address, bits 20..16 PHY address, bits 15..0 data. While the start flag is 0, a bus write stores bit 30, bits 25..0 and the start request. Bus writes to bits 29..26 have no effect.
- R3: Writing 1 to bit 31 sets the start flag only when `en_i` is 1. With `en_i` at 0 the flag stays 0, no frame starts and `idle_o` stays 1. Writing 0 to bit 31 never clears it.
- R4: While the start flag is 1, every bus write is ignored and all fields keep their values.
- R5: The start flag clears by itself once the frame on the wire is complete, and `idle_o` then returns to 1.
- R6: A write access drives 64 bits, MSB first, with `mdio_oe_o` high throughout. The bits are 32 ones, then 01, then opcode 01, the 5-bit PHY address, the 5-bit register address, turnaround 10, and the 16 data bits.
- R7: A read access drives 46 bits: 32 ones, 01, opcode 10, the PHY address and the register address. It then releases the line (`mdio_oe_o` = 0) for the remaining 18 bit slots.
- R8: On a read where the PHY drives the second turnaround bit low, the acknowledge flag becomes 1 and the data field holds the 16 bits the PHY returned, MSB first.
- R9: On a read where the second turnaround bit is high (no PHY answers), the acknowledge flag stays 0 and the data field becomes 0xFFFF.
- R10: `mdc_o` has a period of max(`div_i`, 2) system clocks and is high for that count minus half of it (rounded down). `mdio_o` changes only on a falling edge of `mdc_o`, and the first frame bit is driven at a falling edge.
- R11: Accepting a new start clears the acknowledge flag, so the flag always describes the latest access.
- R12: `idle_o` is 1 exactly when the start flag is 0 and no frame is in progress. `mdio_oe_o` is 0 whenever `idle_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Engine enable; gates acceptance of the start flag |
| div_i | input | 8 | Management clock divisor in system clocks (values below 2 act as 2) |
| bus_wr_i | input | 1 | Command word write strobe |
| bus_wdata_i | input | 32 | Command word write data |
| bus_rdata_o | output | 32 | Current command word |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |
| idle_o | output | 1 | No access pending or in progress |

## Verification
The hardest cases to reach from the ports are the read paths, because they depend on a PHY that answers in step with `mdc_o`. The bench models such a PHY. It reconstructs the frame from `mdio_o` at each rising edge of `mdc_o`, decodes the opcode and PHY address, and drives the turnaround zero and the reply data on the following falling edges. When the addressed PHY does not match, it leaves the line pulled high, which produces the missing-acknowledge case. A bus write is also issued in the middle of a running frame, to check the lock.

// File: rtl/mdio_acc_pkg.sv
package mdio_acc_pkg;

  localparam int FRAME_LEN  = 64;
  localparam int PRE_LEN    = 32;
  localparam int TA_POS     = 46;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 5;

  localparam int POS_GO     = 31;
  localparam int POS_WR     = 30;
  localparam int POS_ACK    = 29;
  localparam int POS_REG_LO = 21;
  localparam int POS_PHY_LO = 16;

  typedef enum logic {ENG_IDLE, ENG_RUN} eng_state_e;

  function automatic logic [FRAME_LEN-1:0] build_frame(
    input logic              wr,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] rg,
    input logic [DATA_W-1:0] data
  );
    logic [1:0] op;
    logic [1:0] ta;
    logic [DATA_W-1:0] pay;
    op  = wr ? 2'b01 : 2'b10;
    ta  = wr ? 2'b10 : 2'b11;
    pay = wr ? data : {DATA_W{1'b1}};
    return {{PRE_LEN{1'b1}}, 2'b01, op, phy, rg, ta, pay};
  endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_stb_o,
  output logic             fall_stb_o
);

  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  logic [DIV_W-1:0] eff_div;
  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;

  always_comb begin
    eff_div    = (div_i < MIN_DIV) ? MIN_DIV : div_i;
    half       = eff_div >> 1;
    fall_stb_o = (cnt_q >= eff_div - DIV_W'(1));
    rise_stb_o = (cnt_q == half - DIV_W'(1));
    cnt_d      = fall_stb_o ? '0 : cnt_q + DIV_W'(1);
    mdc_d      = mdc_q;
    if (fall_stb_o)      mdc_d = 1'b0;
    else if (rise_stb_o) mdc_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc_o = mdc_q;

  // R10: the clock only rises on a rise strobe and only falls on a fall strobe
  p_mdc_edges_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc_q) |-> $past(rise_stb_o));

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_acc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_stb_i,
  input  logic              rise_stb_i,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int CNT_W = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] REL_BIT  = CNT_W'(TA_POS - 1);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(TA_POS + 1);
  localparam logic [CNT_W-1:0] DAT_BIT  = CNT_W'(TA_POS + 2);

  eng_state_e             state_q, state_d;
  logic [FRAME_LEN-1:0]   sreg_q, sreg_d;
  logic [FRAME_LEN-1:0]   frame;
  logic [CNT_W-1:0]       bit_q, bit_d;
  logic                   mdo_q, mdo_d;
  logic                   oe_q, oe_d;
  logic                   rd_q, rd_d;
  logic                   ack_q, ack_d;
  logic [DATA_W-1:0]      rdat_q, rdat_d;

  always_comb begin
    frame   = build_frame(wr_i, phy_i, reg_i, wdata_i);
    state_d = state_q;
    sreg_d  = sreg_q;
    bit_d   = bit_q;
    mdo_d   = mdo_q;
    oe_d    = oe_q;
    rd_d    = rd_q;
    ack_d   = ack_q;
    rdat_d  = rdat_q;
    done_o  = 1'b0;
    case (state_q)
      ENG_IDLE: begin
        if (fall_stb_i && start_i) begin
          state_d = ENG_RUN;
          mdo_d   = frame[FRAME_LEN-1];
          sreg_d  = {frame[FRAME_LEN-2:0], 1'b0};
          bit_d   = '0;
          oe_d    = 1'b1;
          rd_d    = !wr_i;
          ack_d   = 1'b0;
          rdat_d  = '0;
        end
      end
      default: begin
        if (fall_stb_i) begin
          if (bit_q == LAST_BIT) begin
            state_d = ENG_IDLE;
            oe_d    = 1'b0;
            mdo_d   = 1'b1;
            done_o  = 1'b1;
          end else begin
            bit_d  = bit_q + CNT_W'(1);
            mdo_d  = sreg_q[FRAME_LEN-1];
            sreg_d = {sreg_q[FRAME_LEN-2:0], 1'b0};
            if (rd_q && bit_q >= REL_BIT) oe_d = 1'b0;
          end
        end else if (rise_stb_i && rd_q) begin
          if (bit_q == ACK_BIT) ack_d = !mdio_i;
          if (bit_q >= DAT_BIT) rdat_d = {rdat_q[DATA_W-2:0], mdio_i};
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      sreg_q  <= '0;
      bit_q   <= '0;
      mdo_q   <= 1'b1;
      oe_q    <= 1'b0;
      rd_q    <= 1'b0;
      ack_q   <= 1'b0;
      rdat_q  <= '0;
    end else begin
      state_q <= state_d;
      sreg_q  <= sreg_d;
      bit_q   <= bit_d;
      mdo_q   <= mdo_d;
      oe_q    <= oe_d;
      rd_q    <= rd_d;
      ack_q   <= ack_d;
      rdat_q  <= rdat_d;
    end
  end

  assign mdio_o    = mdo_q;
  assign mdio_oe_o = oe_q;
  assign busy_o    = (state_q == ENG_RUN);
  assign ack_o     = ack_q;
  assign rdata_o   = rdat_q;

  // R7: a read never drives the line past the register address
  p_read_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q && bit_q >= CNT_W'(TA_POS)) |-> !oe_q);

endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg
  import mdio_acc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              bus_wr_i,
  input  logic [31:0]       bus_wdata_i,
  input  logic              done_i,
  input  logic              eng_ack_i,
  input  logic [DATA_W-1:0] eng_rdata_i,
  output logic              go_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] phy_o,
  output logic [ADDR_W-1:0] reg_o,
  output logic [DATA_W-1:0] data_o,
  output logic [31:0]       word_o
);

  logic              go_q, go_d;
  logic              wr_q, wr_d;
  logic              ack_q, ack_d;
  logic [ADDR_W-1:0] phy_q, phy_d;
  logic [ADDR_W-1:0] reg_q, reg_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              accept;

  always_comb begin
    go_d   = go_q;
    wr_d   = wr_q;
    ack_d  = ack_q;
    phy_d  = phy_q;
    reg_d  = reg_q;
    data_d = data_q;
    accept = bus_wr_i && !go_q;
    if (done_i) begin
      go_d = 1'b0;
      if (!wr_q) begin
        ack_d  = eng_ack_i;
        data_d = eng_ack_i ? eng_rdata_i : {DATA_W{1'b1}};
      end
    end else if (accept) begin
      wr_d   = bus_wdata_i[POS_WR];
      reg_d  = bus_wdata_i[POS_REG_LO +: ADDR_W];
      phy_d  = bus_wdata_i[POS_PHY_LO +: ADDR_W];
      data_d = bus_wdata_i[DATA_W-1:0];
      if (bus_wdata_i[POS_GO] && en_i) begin
        go_d  = 1'b1;
        ack_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q   <= 1'b0;
      wr_q   <= 1'b0;
      ack_q  <= 1'b0;
      phy_q  <= '0;
      reg_q  <= '0;
      data_q <= '0;
    end else begin
      go_q   <= go_d;
      wr_q   <= wr_d;
      ack_q  <= ack_d;
      phy_q  <= phy_d;
      reg_q  <= reg_d;
      data_q <= data_d;
    end
  end

  assign go_o   = go_q;
  assign wr_o   = wr_q;
  assign phy_o  = phy_q;
  assign reg_o  = reg_q;
  assign data_o = data_q;
  assign word_o = {go_q, wr_q, ack_q, 3'b000, reg_q, phy_q, data_q};

  p_go_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go_q) |-> $past(en_i));

  p_locked_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && bus_wr_i && !done_i) |=> ($stable(wr_q) && $stable(phy_q) &&
                                       $stable(reg_q) && $stable(data_q)));

  p_go_self_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !go_q);

  p_ack_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> !wr_q);

endmodule

// File: rtl/mdio_acc_ctrl.sv
module mdio_acc_ctrl
  import mdio_acc_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             bus_wr_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  output logic             mdc_o,
  output logic             mdio_o,
  output logic             mdio_oe_o,
  input  logic             mdio_i,
  output logic             idle_o
);

  logic              rise_stb, fall_stb;
  logic              go, wr, busy, done, eng_ack;
  logic [ADDR_W-1:0] phy, rg;
  logic [DATA_W-1:0] data, eng_rdata;

  mdio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_i      (div_i),
    .mdc_o      (mdc_o),
    .rise_stb_o (rise_stb),
    .fall_stb_o (fall_stb)
  );

  mdio_cmd_reg u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .bus_wr_i    (bus_wr_i),
    .bus_wdata_i (bus_wdata_i),
    .done_i      (done),
    .eng_ack_i   (eng_ack),
    .eng_rdata_i (eng_rdata),
    .go_o        (go),
    .wr_o        (wr),
    .phy_o       (phy),
    .reg_o       (rg),
    .data_o      (data),
    .word_o      (bus_rdata_o)
  );

  mdio_frame_eng u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .fall_stb_i (fall_stb),
    .rise_stb_i (rise_stb),
    .start_i    (go && en_i),
    .wr_i       (wr),
    .phy_i      (phy),
    .reg_i      (rg),
    .wdata_i    (data),
    .mdio_i     (mdio_i),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o),
    .busy_o     (busy),
    .done_o     (done),
    .ack_o      (eng_ack),
    .rdata_o    (eng_rdata)
  );

  assign idle_o = !go && !busy;

  // R10: data line moves only together with a falling management clock
  p_mdo_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> $fell(mdc_o));

  p_oe_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe_o) |-> $fell(mdc_o));

  p_idle_no_drive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> !mdio_oe_o);

endmodule

// File: tb/test_mdio_acc_ctrl.sv
module test_mdio_acc_ctrl;

  logic        clk;
  logic        rst_n;
  logic        en_i;
  logic [7:0]  div_i;
  logic        bus_wr_i;
  logic [31:0] bus_wdata_i;
  logic [31:0] bus_rdata_o;
  logic        mdc_o, mdio_o, mdio_oe_o, mdio_i, idle_o;

  int checks;
  int fails;
  int cyc;

  // PHY model state
  logic [63:0] cap;
  int          k;
  int          oe_bits;
  logic        frame_on;
  logic [4:0]  resp_phy;
  logic [15:0] resp_data;

  mdio_acc_ctrl i_mdio_acc_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .div_i       (div_i),
    .bus_wr_i    (bus_wr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .mdc_o       (mdc_o),
    .mdio_o      (mdio_o),
    .mdio_oe_o   (mdio_oe_o),
    .mdio_i      (mdio_i),
    .idle_o      (idle_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge mdio_oe_o) begin
    if (!frame_on) begin
      frame_on = 1'b1;
      k        = 0;
      oe_bits  = 0;
      cap      = '0;
    end
  end

  always @(posedge mdc_o) begin
    if (frame_on) begin
      if (mdio_oe_o) begin
        cap[63-k] = mdio_o;
        oe_bits   = oe_bits + 1;
      end
      k = k + 1;
      if (k == 64) frame_on = 1'b0;
    end
  end

  always @(negedge mdc_o) begin
    if (frame_on && k >= 46 && cap[29:28] == 2'b10 && cap[27:23] == resp_phy) begin
      if (k == 46)      mdio_i = 1'b1;
      else if (k == 47) mdio_i = 1'b0;
      else              mdio_i = resp_data[63-k];
    end else begin
      mdio_i = 1'b1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] w);
    @(negedge clk);
    bus_wr_i    = 1'b1;
    bus_wdata_i = w;
    @(negedge clk);
    bus_wr_i    = 1'b0;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (!idle_o && n < 5000) begin
      @(negedge clk);
      n = n + 1;
    end
    chk("R5 timeout", 64'(idle_o), 64'd1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 word", 64'(bus_rdata_o), 64'h0);
    chk("R1 idle", 64'(idle_o), 64'd1);
    chk("R1 oe", 64'(mdio_oe_o), 64'd0);
    chk("R1 mdc", 64'(mdc_o), 64'd0);
  endtask

  task automatic t_layout();
    en_i = 1'b0;
    bus_write(32'h7FFF_ABCD);
    chk("R2 layout", 64'(bus_rdata_o), 64'h43FF_ABCD);
  endtask

  task automatic t_go_disabled();
    en_i = 1'b0;
    bus_write(32'h8025_0001);
    chk("R3 go gated", 64'(bus_rdata_o), 64'h0025_0001);
    repeat (40) @(negedge clk);
    chk("R3 stays idle", 64'({idle_o, mdio_oe_o}), 64'b10);
  endtask

  task automatic t_write_frame();
    logic [31:0] cmd;
    cmd  = 32'hC000_0000 | (32'h0A << 21) | (32'h05 << 16) | 32'h1234;
    en_i = 1'b1;
    div_i = 8'd4;
    bus_write(cmd);
    chk("R3 go set", 64'(bus_rdata_o), 64'(cmd));
    chk("R12 busy not idle", 64'(idle_o), 64'd0);
    repeat (60) @(negedge clk);
    chk("R12 drive mid frame", 64'(mdio_oe_o), 64'd1);
    bus_write(32'h0000_0000);
    chk("R4 locked", 64'(bus_rdata_o), 64'(cmd));
    wait_idle();
    chk("R5 go cleared", 64'(bus_rdata_o), 64'(cmd & 32'h7FFF_FFFF));
    chk("R6 frame", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h05, 5'h0A, 2'b10, 16'h1234});
    chk("R6 drive count", 64'(oe_bits), 64'd64);
    chk("R12 released", 64'(mdio_oe_o), 64'd0);
  endtask

  task automatic t_read_ack();
    logic [31:0] cmd;
    resp_phy  = 5'h05;
    resp_data = 16'hBEEF;
    div_i = 8'd5;
    cmd = 32'h8000_0000 | (32'h03 << 21) | (32'h05 << 16);
    bus_write(cmd);
    wait_idle();
    chk("R8 ack and data", 64'(bus_rdata_o), 64'h2000_0000 | (64'h03 << 21) | (64'h05 << 16) | 64'hBEEF);
    chk("R7 header", 64'(cap[63:18]), 64'({32'hFFFF_FFFF, 2'b01, 2'b10, 5'h05, 5'h03}));
    chk("R7 drive count", 64'(oe_bits), 64'd46);
  endtask

  task automatic t_read_noack();
    logic [31:0] cmd;
    resp_phy = 5'h05;
    div_i = 8'd2;
    cmd = 32'h8000_5555 | (32'h11 << 21) | (32'h07 << 16);
    bus_write(cmd);
    chk("R11 ack cleared", 64'(bus_rdata_o[29]), 64'd0);
    wait_idle();
    chk("R9 no ack", 64'(bus_rdata_o), (64'h11 << 21) | (64'h07 << 16) | 64'hFFFF);
  endtask

  task automatic measure(input logic [7:0] d, input int per, input int hi);
    int t0, t1, t2;
    div_i = d;
    @(posedge mdc_o);
    @(posedge mdc_o);
    t0 = cyc;
    @(negedge mdc_o);
    t1 = cyc;
    @(posedge mdc_o);
    t2 = cyc;
    chk("R10 period", 64'(t2 - t0), 64'(per));
    chk("R10 high time", 64'(t1 - t0), 64'(hi));
  endtask

  task automatic t_mdc();
    measure(8'd5, 5, 3);
    measure(8'd0, 2, 1);
    measure(8'd8, 8, 4);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails  = fails + 1;
    checks = checks + 1;
    $display("FAIL watchdog: actual expired expected completion");
    finish_run();
  end

  initial begin
    checks = 0;
    fails = 0;
    cyc = 0;
    frame_on = 1'b0;
    k = 0;
    oe_bits = 0;
    cap = '0;
    resp_phy = 5'h1F;
    resp_data = '0;
    mdio_i = 1'b1;
    rst_n = 1'b0;
    en_i = 1'b0;
    div_i = 8'd4;
    bus_wr_i = 1'b0;
    bus_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_layout();
    t_go_disabled();
    t_write_frame();
    t_read_ack();
    t_read_noack();
    t_mdc();
    finish_run();
  end

endmodule